// File: doc/BRIEF.md
# Calendar Time-of-Day Counter

This block keeps a running binary calendar and clock: year, month, day of month, day of week, hour, minute and second. A prescaler divides the reference clock down to one tick per second. The divisor is programmed as the wanted period minus one.

Software writes a new date and time into two staging words, then writes the control word with its load bit set. That copies the staged values into the live counters on the same clock edge. A leap-year override lets software turn off February 29 for century years that are not multiples of 400.

The live values come out through two words. Reading the time word also captures the date, so a date read that follows returns the date that belongs with that time, even if midnight has passed in between.

Top module: `cal_clock`

## Requirements
- R1: While the counter is active, one second tick occurs every DIV+1 reference clocks, where DIV is the value in the divisor word (select 0, bits [15:0]). Each tick advances the second field by one.
- R2: While the counter is inactive, the prescaler is held at zero and the live time and date do not change.
- R3: The control word (select 3) holds the run enable in bit 0 and the leap override in bit 1. It shows the active flag in bit 3, and that flag equals the run enable of the previous clock.
- R4: Writing the control word with bit 2 set copies both staging words into the live counters on that edge, whether or not the counter is running. Bit 2 always reads back as 0.
- R5: The time word (select 2 staged, select 4 live) packs second [5:0], minute [11:6], hour [16:12] and day of week [19:17]. Seconds wrap 59 to 0 and carry into minutes, minutes wrap 59 to 0 and carry into hours, and hours wrap 23 to 0 and carry into the day.
- R6: The date word (select 1 staged, select 5 captured) packs day [4:0], month [8:5] and year [20:9]. After the last day of a month the day becomes 1 and the month increments. April, June, September and November have 30 days; every other month except February has 31.
- R7: February has 29 days when the year's two low bits are zero and the leap override is clear. Otherwise it has 28.
- R8: Every day carry advances the day of week (0 is Sunday, 1 is Monday through 6 is Saturday), wrapping from 6 to 0.
- R9: A month carry out of 12 sets the month to 1 and increments the year.
- R10: A read strobe on select 4 captures the live date. Select 5 returns that captured date until the next such read.
- R11: After reset, every readable word is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Write select: 0 divisor, 1 staged date, 2 staged time, 3 control |
| wr_data | input | 21 | Write data |
| rd_en | input | 1 | Read strobe; on select 4 it captures the date |
| rd_sel | input | 3 | Read select: 0 to 3 as for writes, 4 live time, 5 captured date |
| rd_data | output | 21 | Read data, combinational from rd_sel |

## Verification
The clock is loaded with values one second before midnight at several month ends, so each run isolates a single calendar decision. The cases are December 31 (year carry and day-of-week wrap), February 28 in a leap year, a plain year and an overridden century year, February 29, a 30-day month end, and a mid-month day, which must not carry. Three divisor values (0, 3 and 5) are checked by measuring the gap between second ticks, which separates an off-by-one period from a correct one. A time read before midnight followed by a date read after it shows whether the capture register or the live date is returned.

// File: rtl/cal_clock.sv
module cal_clock #(
  parameter int DIV_W  = 16,
  parameter int YEAR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [YEAR_W+8:0] wr_data,
  input  logic              rd_en,
  input  logic [2:0]        rd_sel,
  output logic [YEAR_W+8:0] rd_data
);
  localparam int DW  = YEAR_W + 9;
  localparam int TW  = 20;
  localparam logic [2:0] S_DIV = 3'd0, S_SDATE = 3'd1, S_STIME = 3'd2,
                         S_CTRL = 3'd3, S_TIME = 3'd4, S_SNAP = 3'd5;

  logic [DIV_W-1:0]  div_q, pre_q;
  logic              en_q, noleap_q, active_q;
  logic [DW-1:0]     stg_date, snap_date;
  logic [TW-1:0]     stg_time;
  logic [YEAR_W-1:0] yr;
  logic [3:0]        mo;
  logic [4:0]        dy, hr, dim;
  logic [2:0]        dw;
  logic [5:0]        mi, se;

  wire load      = wr_en && wr_sel == S_CTRL && wr_data[2];
  wire tick      = active_q && pre_q == div_q;
  wire leap      = yr[1:0] == 2'b00 && !noleap_q;
  wire sec_end   = se >= 6'd59;
  wire min_end   = mi >= 6'd59;
  wire hour_end  = hr >= 5'd23;
  wire day_carry = sec_end && min_end && hour_end;
  wire [DW-1:0] live_date = {yr, mo, dy};
  wire [TW-1:0] live_time = {dw, hr, mi, se};

  always_comb begin
    case (mo)
      4'd2:                      dim = leap ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:   dim = 5'd30;
      default:                   dim = 5'd31;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0; en_q <= 1'b0; noleap_q <= 1'b0; active_q <= 1'b0;
      pre_q <= '0; stg_date <= '0; stg_time <= '0; snap_date <= '0;
    end else begin
      active_q <= en_q;
      if (!active_q || tick) pre_q <= '0;
      else                   pre_q <= pre_q + 1'b1;
      if (wr_en) begin
        case (wr_sel)
          S_DIV:   div_q    <= wr_data[DIV_W-1:0];
          S_SDATE: stg_date <= wr_data;
          S_STIME: stg_time <= wr_data[TW-1:0];
          S_CTRL:  begin en_q <= wr_data[0]; noleap_q <= wr_data[1]; end
          default: ;
        endcase
      end
      if (rd_en && rd_sel == S_TIME) snap_date <= live_date;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      yr <= '0; mo <= '0; dy <= '0; dw <= '0; hr <= '0; mi <= '0; se <= '0;
    end else if (load) begin
      {yr, mo, dy}     <= stg_date;
      {dw, hr, mi, se} <= stg_time;
    end else if (tick) begin
      se <= sec_end ? 6'd0 : se + 6'd1;
      if (sec_end) mi <= min_end ? 6'd0 : mi + 6'd1;
      if (sec_end && min_end) hr <= hour_end ? 5'd0 : hr + 5'd1;
      if (day_carry) begin
        dw <= (dw >= 3'd6) ? 3'd0 : dw + 3'd1;
        if (dy >= dim) begin
          dy <= 5'd1;
          if (mo >= 4'd12) begin
            mo <= 4'd1;
            yr <= yr + 1'b1;
          end else begin
            mo <= mo + 4'd1;
          end
        end else begin
          dy <= dy + 5'd1;
        end
      end
    end
  end

  always_comb begin
    case (rd_sel)
      S_DIV:   rd_data = DW'(div_q);
      S_SDATE: rd_data = stg_date;
      S_STIME: rd_data = DW'(stg_time);
      S_CTRL:  rd_data = DW'({active_q, 1'b0, noleap_q, en_q});
      S_TIME:  rd_data = DW'(live_time);
      S_SNAP:  rd_data = snap_date;
      default: rd_data = '0;
    endcase
  end

  a_r3_active_follows: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> active_q == $past(en_q));
  a_r2_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q && !load) |=> ($stable(live_date) && $stable(live_time)));
  a_r4_load_copies: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (live_date == $past(stg_date) && live_time == $past(stg_time)));
  a_r5_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && sec_end) |=> se == 6'd0);
  a_r8_dow_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && day_carry && dw == 3'd6) |=> dw == 3'd0);
  a_r10_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_sel == S_TIME) |=> snap_date == $past(live_date));
endmodule

// File: tb/cal_clock_test.sv
module cal_clock_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  wr_sel = '0, rd_sel = '0;
  logic [20:0] wr_data = '0;
  logic [20:0] rd_data;
  int errors = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cal_clock uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data));

  function automatic int pdate(int y, int m, int d);
    return (y << 9) | (m << 5) | d;
  endfunction
  function automatic int ptime(int w, int h, int mi, int s);
    return (w << 17) | (h << 12) | (mi << 6) | s;
  endfunction

  // behavioural reference
  int m_div, m_pre, m_sd, m_st, m_snap;
  int m_y, m_mo, m_d, m_w, m_h, m_mi, m_s;
  bit m_en, m_nl, m_act;

  function automatic int mdays(int mo, int y, bit nl);
    if (mo == 2) return (y % 4 == 0 && !nl) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic int expect_rd(int sel);
    case (sel)
      0: return m_div;
      1: return m_sd;
      2: return m_st;
      3: return (int'(m_act) << 3) | (int'(m_nl) << 1) | int'(m_en);
      4: return ptime(m_w, m_h, m_mi, m_s);
      5: return m_snap;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_div = 0; m_pre = 0; m_sd = 0; m_st = 0; m_snap = 0; m_en = 0; m_nl = 0; m_act = 0;
      m_y = 0; m_mo = 0; m_d = 0; m_w = 0; m_h = 0; m_mi = 0; m_s = 0;
    end else begin
      bit ld, tk;
      ld = wr_en && wr_sel == 3 && wr_data[2];
      tk = m_act && m_pre == m_div;
      if (rd_en && rd_sel == 4) m_snap = pdate(m_y, m_mo, m_d);
      if (ld) begin
        m_y = (m_sd >> 9) & 12'hfff; m_mo = (m_sd >> 5) & 15; m_d = m_sd & 31;
        m_w = (m_st >> 17) & 7; m_h = (m_st >> 12) & 31; m_mi = (m_st >> 6) & 63; m_s = m_st & 63;
      end else if (tk) begin
        m_s++;
        if (m_s == 60) begin m_s = 0; m_mi++; end
        if (m_mi == 60) begin m_mi = 0; m_h++; end
        if (m_h == 24) begin
          m_h = 0; m_w = (m_w + 1) % 7; m_d++;
          if (m_d > mdays(m_mo, m_y, m_nl)) begin m_d = 1; m_mo++; end
          if (m_mo == 13) begin m_mo = 1; m_y = (m_y + 1) % 4096; end
        end
      end
      m_pre = (!m_act || tk) ? 0 : m_pre + 1;
      m_act = m_en;
      if (wr_en) case (wr_sel)
        0: m_div = wr_data[15:0];
        1: m_sd = wr_data;
        2: m_st = wr_data[19:0];
        3: begin m_en = wr_data[0]; m_nl = wr_data[1]; end
        default: ;
      endcase
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int e;
      e = expect_rd(rd_sel);
      checks++;
      if (int'(rd_data) != e) begin
        errors++;
        $display("FAIL %s sel=%0d actual=%h expected=%h",
          rd_sel == 4 ? "R5" : rd_sel == 5 ? "R10" : rd_sel == 3 ? "R3" : "R4",
          rd_sel, rd_data, e);
      end
    end
  end

  task automatic chk(input int sel, input int mask, input int exp, input string tag);
    rd_sel = 3'(sel);
    #1;
    checks++;
    if ((int'(rd_data) & mask) != exp) begin
      errors++;
      $display("FAIL %s sel=%0d actual=%h expected=%h", tag, sel, int'(rd_data) & mask, exp);
    end
  endtask

  task automatic wr(input int sel, input int data);
    @(negedge clk); #1;
    wr_en = 1; wr_sel = 3'(sel); wr_data = 21'(data);
    @(negedge clk); #1;
    wr_en = 0;
  endtask

  task automatic capture;
    @(negedge clk); #1;
    rd_sel = 3'd4; rd_en = 1;
    @(negedge clk); #1;
    rd_en = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic rollover(input int d0, input int w0, input bit nl, input int d1, input int w1, input string tag);
    wr(1, d0);
    wr(2, ptime(w0, 23, 59, 59));
    wr(3, 32'h5 | (int'(nl) << 1));
    idle(10);
    capture();
    chk(5, 32'h1fffff, d1, tag);
    chk(4, 32'hfffc0, ptime(w1, 0, 0, 0), "R8");
  endtask

  task automatic period(input int dv, input string tag);
    int prev, gap;
    wr(3, 0);
    wr(0, dv);
    wr(2, 0);
    wr(3, 32'h5);
    rd_sel = 3'd4;
    idle(1);
    prev = rd_data[5:0];
    for (int i = 0; i < 50 && rd_data[5:0] == prev; i++) idle(1);
    prev = rd_data[5:0]; gap = 0;
    for (int i = 0; i < 50 && rd_data[5:0] == prev; i++) begin idle(1); gap++; end
    checks++;
    if (gap != dv + 1) begin
      errors++;
      $display("FAIL %s tick gap actual=%0d expected=%0d", tag, gap, dv + 1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1; errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1;
    idle(1);
    for (int s = 0; s < 6; s++) chk(s, 32'h1fffff, 0, "R11");

    period(3, "R1");
    period(0, "R1");
    period(5, "R1");
    wr(0, 3);

    rollover(pdate(2023, 12, 31), 6, 0, pdate(2024, 1, 1), 0, "R9");
    rollover(pdate(2024, 2, 28), 3, 0, pdate(2024, 2, 29), 4, "R7");
    rollover(pdate(2024, 2, 29), 4, 0, pdate(2024, 3, 1), 5, "R7");
    rollover(pdate(2100, 2, 28), 0, 1, pdate(2100, 3, 1), 1, "R7");
    rollover(pdate(2023, 2, 28), 2, 0, pdate(2023, 3, 1), 3, "R6");
    rollover(pdate(2023, 4, 30), 2, 0, pdate(2023, 5, 1), 3, "R6");
    rollover(pdate(2023, 5, 30), 5, 0, pdate(2023, 5, 31), 6, "R6");

    // R2: disable, time frozen
    wr(3, 0);
    idle(2);
    chk(3, 32'h8, 0, "R3");
    begin
      int t0;
      rd_sel = 3'd4; #1; t0 = rd_data;
      idle(20);
      chk(4, 32'hfffff, t0, "R2");
    end

    // R4: load while disabled, bit 2 reads 0
    wr(1, pdate(2030, 1, 31));
    wr(2, ptime(1, 23, 59, 59));
    wr(3, 32'h4);
    chk(4, 32'hfffff, ptime(1, 23, 59, 59), "R4");
    chk(3, 32'h4, 0, "R4");

    // R10: capture before midnight, read after
    capture();
    wr(3, 32'h1);
    chk(3, 32'h9, 1, "R3");
    idle(1);
    chk(3, 32'h9, 9, "R3");
    idle(10);
    chk(5, 32'h1fffff, pdate(2030, 1, 31), "R10");
    capture();
    chk(5, 32'h1fffff, pdate(2030, 2, 1), "R10");
    chk(4, 32'he0000, ptime(2, 0, 0, 0), "R8");

    idle(2);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule